// File: doc/BRIEF.md
# PWM Channel with Duty Fade

This block turns a shared timer count into one pulse-width-modulated output. A 2-bit select picks one of four timer count buses, each with its own overflow strobe. The output rises when the chosen count meets a programmable high point. It falls a duty length later, and the fall point wraps inside the timer range. The duty value is 25 bits wide: 21 integer bits of counts and 4 fractional bits. The fraction is spread over sixteen-period cycles by stretching some periods one count longer.

A small fade sequencer can walk the duty up or down without software help. It applies a programmed step size every programmed number of PWM periods, for a programmed number of steps. It saturates at zero and at full scale, and it pulses a done flag after the last step. The duty and fade settings are staged. They are captured only at the first timer overflow after a start pulse, and the pending start then clears itself, so every period is produced whole. The output-enable and idle-level inputs act at once. When output is disabled, the pin drives the idle level.

Top module: `pwmfade_chan`

## Requirements
- R1: `cfg_tsel_i` selects which of the four count/overflow pairs drives the channel. Field k takes count bits [20k+19:20k] and overflow bit k.
- R2: With a duty of D counts (0 < D < range, range = 2^`cfg_res_i`), the output goes high in the cycle after the count equals `cfg_hpoint_i`. It goes low in the cycle after the count equals (hpoint + D) mod range, so it is high for exactly D cycles per period, including when the window wraps past the range end.
- R3: An effective duty of 0 keeps the output low. An effective duty at or above the range keeps it high for the whole period.
- R4: `cfg_duty_i` bits [3:0] are a fraction F/16. Over the sixteen periods that follow a start, exactly F of the periods are one count longer than the integer duty.
- R5: Duty and fade settings are ignored until `start_i` is pulsed. They take effect at the next overflow of the selected timer, and a pending start is consumed there. Settings changed later without a new pulse have no effect.
- R6: While `cfg_oe_i` is 0, `pwm_o` follows `cfg_idle_i` one cycle later.
- R7: With `fade_num_i` = N > 0 and `fade_cyc_i` = C (0 is treated as 1), the integer duty changes by `fade_scale_i` every C periods, N times. `fade_up_i` = 1 adds the step and 0 subtracts it.
- R8: During a fade the integer duty saturates at 0 when decreasing and at the range when increasing.
- R9: `fade_done_o` pulses high for one cycle, right after the overflow that applies the last fade step, and only once per fade.
- R10: During reset `pwm_o` and `fade_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_cnt_i | input | 80 | Four packed 20-bit timer counts |
| tmr_ovf_i | input | 4 | Overflow strobes, high in each timer's last count cycle |
| cfg_tsel_i | input | 2 | Timer select |
| cfg_res_i | input | 5 | Timer range as log2 of counts per period |
| cfg_hpoint_i | input | 20 | Count at which the output rises |
| cfg_duty_i | input | 25 | Staged duty, 21 integer and 4 fraction bits |
| cfg_oe_i | input | 1 | Output enable |
| cfg_idle_i | input | 1 | Level driven while output is disabled |
| fade_up_i | input | 1 | Fade direction, 1 = increase |
| fade_num_i | input | 10 | Number of fade steps |
| fade_cyc_i | input | 10 | Periods between fade steps |
| fade_scale_i | input | 10 | Duty counts per fade step |
| start_i | input | 1 | Start pulse that arms capture of staged settings |
| pwm_o | output | 1 | PWM output level |
| fade_done_o | output | 1 | One-cycle pulse after the last fade step |

## Verification
The hardest state to reach from the ports is a fade that drives the duty past full scale. It also has to be caught in the exact period where saturation and the final step coincide, which is where the done pulse appears. The bench reaches it by loading a duty two counts below the range and using a step larger than that gap with a one-period interval. It then measures the output high time period by period, each window aligned to the selected timer's overflow strobe. Wrap-around and timer selection are checked through the bit pattern of each sampled period, not only its high-count total.

// File: rtl/pwmfade_pkg.sv
package pwmfade_pkg;
   typedef enum logic {
      FADE_DOWN = 1'b0,
      FADE_UP   = 1'b1
   } fade_dir_e;

   parameter int unsigned FADE_W_DEF = 10;
endpackage

// File: rtl/pwmfade_tsel.sv
module pwmfade_tsel #(
   parameter int unsigned CNT_W   = 20,
   parameter int unsigned NUM_TMR = 4,
   localparam int unsigned SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
   input  logic [NUM_TMR*CNT_W-1:0] cnt_bus_i,
   input  logic [NUM_TMR-1:0]       ovf_bus_i,
   input  logic [SEL_W-1:0]         sel_i,
   output logic [CNT_W-1:0]         cnt_o,
   output logic                     ovf_o
);
   logic [CNT_W-1:0] cnt_arr [NUM_TMR];

   for (genvar g = 0; g < NUM_TMR; g++) begin : g_unpack
      assign cnt_arr[g] = cnt_bus_i[g*CNT_W +: CNT_W];
   end

   if ((1 << SEL_W) == NUM_TMR) begin : g_pow2
      assign cnt_o = cnt_arr[sel_i];
      assign ovf_o = ovf_bus_i[sel_i];
   end else begin : g_guard
      always_comb begin
         cnt_o = '0;
         ovf_o = 1'b0;
         for (int k = 0; k < NUM_TMR; k++) begin
            if (sel_i == SEL_W'(k)) begin
               cnt_o = cnt_arr[k];
               ovf_o = ovf_bus_i[k];
            end
         end
      end
   end
endmodule

// File: rtl/pwmfade_seq.sv
module pwmfade_seq
   import pwmfade_pkg::*;
#(
   parameter int unsigned CNT_W   = 20,
   parameter int unsigned FRAC_W  = 4,
   parameter int unsigned FADE_W  = FADE_W_DEF,
   localparam int unsigned INT_W  = CNT_W + 1,
   localparam int unsigned DUTY_W = INT_W + FRAC_W,
   localparam int unsigned EFF_W  = INT_W + 1,
   localparam int unsigned RES_W  = $clog2(CNT_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ovf_i,
   input  logic              start_i,
   input  logic [DUTY_W-1:0] cfg_duty_i,
   input  logic              cfg_up_i,
   input  logic [FADE_W-1:0] cfg_num_i,
   input  logic [FADE_W-1:0] cfg_cyc_i,
   input  logic [FADE_W-1:0] cfg_scale_i,
   input  logic [RES_W-1:0]  res_i,
   output logic [EFF_W-1:0]  eff_o,
   output logic              done_o
);
   logic [DUTY_W-1:0] duty_q;
   logic [FADE_W-1:0] steps_q, cyc_q, scale_q, per_q;
   fade_dir_e         dir_q;
   logic [FRAC_W-1:0] acc_q;
   logic              ext_q, pend_q, done_q;

   logic [INT_W-1:0]  int_cur, full_int, step_int;
   logic [FRAC_W-1:0] frac_cur, step_frac;
   logic [EFF_W-1:0]  up_sum;
   logic [FADE_W-1:0] per_nxt, intv_eff;
   logic              per_hit;
   logic [FRAC_W:0]   acc_sum;

   assign int_cur  = duty_q[DUTY_W-1:FRAC_W];
   assign frac_cur = duty_q[FRAC_W-1:0];
   assign full_int = {{(INT_W-1){1'b0}}, 1'b1} << res_i;
   assign up_sum   = {1'b0, int_cur} + EFF_W'(scale_q);
   assign per_nxt  = per_q + 1'b1;
   assign intv_eff = (cyc_q == '0) ? FADE_W'(1) : cyc_q;
   assign per_hit  = (per_nxt >= intv_eff);
   assign acc_sum  = {1'b0, acc_q} + {1'b0, frac_cur};

   always_comb begin
      step_int  = int_cur;
      step_frac = frac_cur;
      if (dir_q == FADE_UP) begin
         if (up_sum >= {1'b0, full_int}) begin
            step_int  = full_int;
            step_frac = '0;
         end else begin
            step_int = up_sum[INT_W-1:0];
         end
      end else begin
         if (int_cur < INT_W'(scale_q)) begin
            step_int  = '0;
            step_frac = '0;
         end else begin
            step_int = int_cur - INT_W'(scale_q);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q  <= '0;
         steps_q <= '0;
         cyc_q   <= '0;
         scale_q <= '0;
         per_q   <= '0;
         dir_q   <= FADE_DOWN;
         acc_q   <= '0;
         ext_q   <= 1'b0;
         pend_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         pend_q <= start_i | (pend_q & ~ovf_i);
         if (ovf_i && pend_q) begin
            duty_q  <= cfg_duty_i;
            steps_q <= cfg_num_i;
            cyc_q   <= cfg_cyc_i;
            scale_q <= cfg_scale_i;
            dir_q   <= fade_dir_e'(cfg_up_i);
            per_q   <= '0;
            acc_q   <= cfg_duty_i[FRAC_W-1:0];
            ext_q   <= 1'b0;
         end else if (ovf_i) begin
            {ext_q, acc_q} <= acc_sum;
            if (steps_q != '0) begin
               if (per_hit) begin
                  duty_q  <= {step_int, step_frac};
                  steps_q <= steps_q - 1'b1;
                  per_q   <= '0;
                  done_q  <= (steps_q == FADE_W'(1));
               end else begin
                  per_q <= per_nxt;
               end
            end
         end
      end
   end

   assign eff_o  = {1'b0, int_cur} + EFF_W'(ext_q);
   assign done_o = done_q;

   // R5: active duty moves only on an overflow edge
   p_duty_at_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_i |=> $stable(duty_q));
   // R7: step counter only advances on an overflow edge
   p_steps_at_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_i |=> $stable(steps_q));
   // R9: done is a single-cycle pulse
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R9: done follows an overflow
   p_done_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(ovf_i));
endmodule

// File: rtl/pwmfade_cmp.sv
module pwmfade_cmp #(
   parameter int unsigned CNT_W  = 20,
   localparam int unsigned EFF_W = CNT_W + 2,
   localparam int unsigned RES_W = $clog2(CNT_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] hpoint_i,
   input  logic [EFF_W-1:0] eff_i,
   input  logic [RES_W-1:0] res_i,
   input  logic             oe_i,
   input  logic             idle_i,
   output logic             pwm_o
);
   logic [EFF_W-1:0] range_e;
   logic [CNT_W-1:0] mask, lpoint;
   logic             hit_h, hit_l, zero_d, full_d;

   assign range_e = {{(EFF_W-1){1'b0}}, 1'b1} << res_i;
   assign mask    = range_e[CNT_W-1:0] - 1'b1;
   assign lpoint  = (hpoint_i + eff_i[CNT_W-1:0]) & mask;
   assign hit_h   = (cnt_i & mask) == (hpoint_i & mask);
   assign hit_l   = (cnt_i & mask) == lpoint;
   assign zero_d  = (eff_i == '0);
   assign full_d  = (eff_i >= range_e);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pwm_o <= 1'b0;
      else if (!oe_i)  pwm_o <= idle_i;
      else if (zero_d) pwm_o <= 1'b0;
      else if (full_d) pwm_o <= 1'b1;
      else if (hit_l)  pwm_o <= 1'b0;
      else if (hit_h)  pwm_o <= 1'b1;
   end

   // R6: disabled output follows the idle level
   p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_i |=> (pwm_o == $past(idle_i)));
   // R3: zero duty holds the output low
   p_zero_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_i && eff_i == '0) |=> !pwm_o);
   // R3: duty at or above range holds the output high
   p_full_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_i && eff_i != '0 && eff_i >= range_e) |=> pwm_o);
endmodule

// File: rtl/pwmfade_chan.sv
module pwmfade_chan
   import pwmfade_pkg::*;
#(
   parameter int unsigned CNT_W   = 20,
   parameter int unsigned FRAC_W  = 4,
   parameter int unsigned NUM_TMR = 4,
   parameter int unsigned FADE_W  = FADE_W_DEF,
   localparam int unsigned SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1,
   localparam int unsigned RES_W  = $clog2(CNT_W + 1),
   localparam int unsigned DUTY_W = CNT_W + 1 + FRAC_W,
   localparam int unsigned EFF_W  = CNT_W + 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_TMR*CNT_W-1:0] tmr_cnt_i,
   input  logic [NUM_TMR-1:0]       tmr_ovf_i,
   input  logic [SEL_W-1:0]         cfg_tsel_i,
   input  logic [RES_W-1:0]         cfg_res_i,
   input  logic [CNT_W-1:0]         cfg_hpoint_i,
   input  logic [DUTY_W-1:0]        cfg_duty_i,
   input  logic                     cfg_oe_i,
   input  logic                     cfg_idle_i,
   input  logic                     fade_up_i,
   input  logic [FADE_W-1:0]        fade_num_i,
   input  logic [FADE_W-1:0]        fade_cyc_i,
   input  logic [FADE_W-1:0]        fade_scale_i,
   input  logic                     start_i,
   output logic                     pwm_o,
   output logic                     fade_done_o
);
   if (CNT_W < 2 || CNT_W > 30) begin : g_bad_cnt
      $error("pwmfade_chan: CNT_W out of range");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("pwmfade_chan: FRAC_W must be at least 1");
   end
   if (NUM_TMR < 2) begin : g_bad_tmr
      $error("pwmfade_chan: NUM_TMR must be at least 2");
   end
   if (FADE_W < 1 || FADE_W > CNT_W) begin : g_bad_fade
      $error("pwmfade_chan: FADE_W out of range");
   end

   logic [CNT_W-1:0] sel_cnt;
   logic             sel_ovf;
   logic [EFF_W-1:0] eff;

   pwmfade_tsel #(.CNT_W(CNT_W), .NUM_TMR(NUM_TMR)) u_tsel (
      .cnt_bus_i (tmr_cnt_i),
      .ovf_bus_i (tmr_ovf_i),
      .sel_i     (cfg_tsel_i),
      .cnt_o     (sel_cnt),
      .ovf_o     (sel_ovf)
   );

   pwmfade_seq #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .FADE_W(FADE_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ovf_i       (sel_ovf),
      .start_i     (start_i),
      .cfg_duty_i  (cfg_duty_i),
      .cfg_up_i    (fade_up_i),
      .cfg_num_i   (fade_num_i),
      .cfg_cyc_i   (fade_cyc_i),
      .cfg_scale_i (fade_scale_i),
      .res_i       (cfg_res_i),
      .eff_o       (eff),
      .done_o      (fade_done_o)
   );

   pwmfade_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_i    (sel_cnt),
      .hpoint_i (cfg_hpoint_i),
      .eff_i    (eff),
      .res_i    (cfg_res_i),
      .oe_i     (cfg_oe_i),
      .idle_i   (cfg_idle_i),
      .pwm_o    (pwm_o)
   );
endmodule

// File: tb/pwmfade_chan_test.sv
module pwmfade_chan_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [79:0] tmr_cnt;
   logic [3:0]  tmr_ovf;
   logic [1:0]  cfg_tsel = '0;
   logic [4:0]  cfg_res = 5'd4;
   logic [19:0] cfg_hpoint = '0;
   logic [24:0] cfg_duty = '0;
   logic        cfg_oe = 1'b1;
   logic        cfg_idle = 1'b0;
   logic        fade_up = 1'b0;
   logic [9:0]  fade_num = '0;
   logic [9:0]  fade_cyc = '0;
   logic [9:0]  fade_scale = '0;
   logic        start = 1'b0;
   logic        pwm_o, fade_done_o;
   logic [3:0]  base = '0;
   int          total = 0;
   int          fails = 0;
   int          done_cnt = 0;
   logic        ovf_sel;

   always #4 clk = ~clk;

   initial forever begin
      @(posedge clk);
      base <= base + 4'd1;
   end

   always_comb begin
      for (int k = 0; k < 4; k++) begin
         tmr_cnt[k*20 +: 20] = {16'b0, base + 4'(4*k)};
         tmr_ovf[k]          = ((base + 4'(4*k)) == 4'hF);
      end
   end
   assign ovf_sel = tmr_ovf[cfg_tsel];

   pwmfade_chan uut (
      .clk(clk), .rst_n(rst_n), .tmr_cnt_i(tmr_cnt), .tmr_ovf_i(tmr_ovf),
      .cfg_tsel_i(cfg_tsel), .cfg_res_i(cfg_res), .cfg_hpoint_i(cfg_hpoint),
      .cfg_duty_i(cfg_duty), .cfg_oe_i(cfg_oe), .cfg_idle_i(cfg_idle),
      .fade_up_i(fade_up), .fade_num_i(fade_num), .fade_cyc_i(fade_cyc),
      .fade_scale_i(fade_scale), .start_i(start), .pwm_o(pwm_o),
      .fade_done_o(fade_done_o)
   );

   initial forever begin
      @(negedge clk);
      if (fade_done_o) done_cnt++;
   end

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // samples one period; entry and exit at an overflow negedge of the selected timer
   task automatic measure(output int cnt, output logic [15:0] vec);
      cnt = 0;
      vec = '0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         vec[i] = pwm_o;
         cnt += int'(pwm_o);
      end
   endtask

   task automatic launch(logic [1:0] sel, int hp, int dint, int frac,
                         logic up, int num, int cyc, int scale);
      @(negedge clk);
      cfg_tsel   = sel;
      cfg_hpoint = 20'(hp);
      cfg_duty   = {21'(dint), 4'(frac)};
      fade_up    = up;
      fade_num   = 10'(num);
      fade_cyc   = 10'(cyc);
      fade_scale = 10'(scale);
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!ovf_sel) @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R10 pwm in reset", int'(pwm_o), 0);
      chk("R10 done in reset", int'(fade_done_o), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_basic();
      int c; logic [15:0] v;
      launch(2'd0, 0, 5, 0, 1'b0, 0, 0, 0);
      measure(c, v);
      measure(c, v);
      chk("R2 high count duty 5", c, 5);
      chk("R2 window hp0 duty 5", int'(v), 'h003E);
   endtask

   task automatic t_hold();
      int c; logic [15:0] v;
      @(negedge clk);
      cfg_duty = {21'd9, 4'd0};
      while (!ovf_sel) @(negedge clk);
      measure(c, v);
      measure(c, v);
      chk("R5 unstarted duty ignored", c, 5);
      launch(2'd0, 0, 9, 0, 1'b0, 0, 0, 0);
      measure(c, v);
      chk("R5 started duty applied", c, 9);
      cfg_duty = {21'd2, 4'd0};
      measure(c, v);
      measure(c, v);
      chk("R5 start self-cleared", c, 9);
   endtask

   task automatic t_zero_full();
      int c; logic [15:0] v;
      launch(2'd0, 0, 16, 0, 1'b0, 0, 0, 0);
      measure(c, v);
      measure(c, v);
      chk("R3 duty equal range high", c, 16);
      launch(2'd0, 0, 20, 0, 1'b0, 0, 0, 0);
      measure(c, v);
      measure(c, v);
      chk("R3 duty above range high", c, 16);
      launch(2'd0, 3, 0, 0, 1'b0, 0, 0, 0);
      measure(c, v);
      measure(c, v);
      chk("R3 zero duty low", c, 0);
   endtask

   task automatic t_wrap();
      int c; logic [15:0] v;
      launch(2'd0, 14, 4, 0, 1'b0, 0, 0, 0);
      measure(c, v);
      measure(c, v);
      chk("R2 wrap high count", c, 4);
      chk("R2 wrap window", int'(v), 'h8007);
      launch(2'd0, 6, 3, 0, 1'b0, 0, 0, 0);
      measure(c, v);
      measure(c, v);
      chk("R2 hpoint 6 window", int'(v), 'h0380);
   endtask

   task automatic t_dither();
      int c, sum, longp; logic [15:0] v;
      sum = 0; longp = 0;
      launch(2'd0, 0, 4, 4, 1'b0, 0, 0, 0);
      for (int p = 0; p < 16; p++) begin
         measure(c, v);
         sum += c;
         if (c == 5) longp++;
      end
      chk("R4 dither total counts", sum, 68);
      chk("R4 stretched periods", longp, 4);
   endtask

   task automatic t_fade();
      int c; int d0; logic [15:0] v;
      int expv [8] = '{2, 2, 5, 5, 8, 8, 11, 11};
      d0 = done_cnt;
      launch(2'd0, 0, 2, 0, 1'b1, 3, 2, 3);
      for (int p = 0; p < 8; p++) begin
         measure(c, v);
         chk($sformatf("R7 fade period %0d", p + 1), c, expv[p]);
         if (p == 5) chk("R9 no done before last step", done_cnt - d0, 0);
      end
      chk("R9 single done pulse", done_cnt - d0, 1);
   endtask

   task automatic t_sat();
      int c; int d0; logic [15:0] v;
      d0 = done_cnt;
      launch(2'd0, 0, 14, 0, 1'b1, 2, 1, 5);
      measure(c, v);
      chk("R8 before saturation", c, 14);
      measure(c, v);
      measure(c, v);
      chk("R8 saturate at full", c, 16);
      chk("R9 done after saturating fade", done_cnt - d0, 1);
      launch(2'd0, 0, 3, 0, 1'b0, 1, 1, 5);
      measure(c, v);
      measure(c, v);
      chk("R8 saturate at zero", c, 0);
   endtask

   task automatic t_tsel();
      int c; logic [15:0] v;
      launch(2'd1, 0, 4, 0, 1'b0, 0, 0, 0);
      measure(c, v);
      measure(c, v);
      chk("R1 timer 1 window", int'(v), 'h001E);
      launch(2'd3, 0, 4, 0, 1'b0, 0, 0, 0);
      measure(c, v);
      measure(c, v);
      chk("R1 timer 3 window", int'(v), 'h001E);
      cfg_tsel = 2'd0;
   endtask

   task automatic t_oe();
      int c; logic [15:0] v;
      @(negedge clk);
      cfg_oe = 1'b0;
      cfg_idle = 1'b1;
      @(negedge clk);
      measure(c, v);
      chk("R6 idle high", c, 16);
      cfg_idle = 1'b0;
      @(negedge clk);
      measure(c, v);
      chk("R6 idle low", c, 0);
      cfg_oe = 1'b1;
   endtask

   initial begin
      t_reset();
      t_basic();
      t_hold();
      t_zero_full();
      t_wrap();
      t_dither();
      t_fade();
      t_sat();
      t_tsel();
      t_oe();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule